// File: doc/BRIEF.md
# In-Band Control Frame Extractor

This block watches a pixel stream that arrives one 24-bit word per cycle, together with the line number and pixel number of each word. It decides at the first pixel of every frame whether the frame carries ordinary picture content or driver register settings hidden inside a video frame. A picture frame is passed to the video output unchanged, one cycle late. A control frame is kept off the video output for its whole length. Its words are instead sent as register payloads to the downstream serial frame generator.

The first 96 lines of a control frame form three bands of 32 lines each. The first band holds configuration settings, the second holds global pulse-density brightness values, and the third holds calibration current values. In each band, the first two lines hold header words and the next thirty lines hold one row of register data per physical module row. The first 320 pixels of a line are split into five output channels of 64 words each, one word per driver device. Every payload word carries a register-type tag, a header flag, its line offset within the band and its slot within the channel.

Top module: `ctl_frame_extractor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `vidValid`, `ctrlFrame` and all bits of `plChValid` are low.
- R2: A frame is a control frame exactly when its valid pixel at line 0, pixel 0 has bits [23:16] equal to 8'hE8 and bits [15:10] equal to 6'b111111. `ctrlFrame` shows this classification starting in the cycle after that pixel.
- R3: In a picture frame, every valid pixel appears on `vidValid`/`vidData` one cycle later with its data unchanged, and `plChValid` stays zero.
- R4: In a control frame, `vidValid` stays low for every pixel of the frame, including its first pixel.
- R5: Payload words are tagged in `plType` as 0 (configuration) for lines 0–31, 1 (brightness) for lines 32–63 and 2 (calibration) for lines 64–95.
- R6: `plRow` gives the line number modulo 32. `plHdr` is 1 exactly when that offset is 0 or 1.
- R7: In a control frame, a valid pixel p below 320 on a line below 96 raises only bit p/64 of `plChValid` one cycle later. `plSlot` is set to p mod 64 and `plData` carries the pixel word unchanged.
- R8: In a control frame, pixels on lines 96 and above, and pixels numbered 320 and above, produce no payload and no video.
- R9: A frame's classification holds until the next valid pixel at line 0, pixel 0. Cycles with `pixValid` low produce no output and do not change the classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel word present this cycle |
| pixData | input | 24 | Pixel word |
| lineIdx | input | 10 | Line number of the pixel |
| pixIdx | input | 10 | Pixel number within the line |
| vidValid | output | 1 | Picture pixel output valid |
| vidData | output | 24 | Picture pixel word |
| ctrlFrame | output | 1 | Current frame is a control frame |
| plChValid | output | 5 | One-hot channel strobe for a payload word |
| plData | output | 24 | Payload word |
| plType | output | 2 | Register type: 0 configuration, 1 brightness, 2 calibration |
| plHdr | output | 1 | Payload word comes from a header line |
| plRow | output | 5 | Line offset within the 32-line band |
| plSlot | output | 6 | Device slot within the channel |

## Verification
The assertions check on every cycle that at most one channel strobe is active, that video and payload never appear together with the wrong frame class, that tags stay in the legal range, that header flags agree with the row offset, and that output words equal the input word one cycle earlier. The frame classification rule, the exact channel and slot for each pixel, the band-to-type mapping, and the silence outside the 96-line by 320-pixel window can only be shown by the bench's sweeps. The bench covers whole control frames, near-miss header words and frames of different classes in sequence.

// File: rtl/ctl_frame_pkg.sv
package ctl_frame_pkg;
  parameter int NUM_CH      = 5;
  parameter int CH_WORDS    = 64;
  parameter int GROUP_LINES = 32;
  parameter int NUM_GROUPS  = 3;
  parameter int HDR_LINES   = 2;
  parameter int WORD_W      = 24;
  parameter logic [7:0] SYNC_BYTE = 8'hE8;
  parameter logic [5:0] CMD_CFG   = 6'b111111;

  localparam int CH_W   = $clog2(NUM_CH);
  localparam int SLOT_W = $clog2(CH_WORDS);
  localparam int ROW_W  = $clog2(GROUP_LINES);
  localparam int TYPE_W = 2;

  typedef enum logic [TYPE_W-1:0] {
    REG_CFG = 2'd0,
    REG_PDM = 2'd1,
    REG_CAL = 2'd2
  } regType_e;

  typedef struct packed {
    logic             fwdPl;
    logic             vidPass;
    logic [CH_W-1:0]  chan;
    regType_e         plType;
    logic             hdr;
    logic [ROW_W-1:0] row;
    logic [SLOT_W-1:0] slot;
  } ctlStrobes_t;
endpackage

// File: rtl/ctl_frame_ctrl.sv
module ctl_frame_ctrl
  import ctl_frame_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int PIX_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic [WORD_W-1:0] pixData,
  input  logic [LINE_W-1:0] lineIdx,
  input  logic [PIX_W-1:0]  pixIdx,
  output ctlStrobes_t       stb,
  output logic              frameIsCtl
);
  localparam int MAP_LINES = NUM_GROUPS * GROUP_LINES;
  localparam int MAP_PIX   = NUM_CH * CH_WORDS;

  logic sof;
  logic headerMatch;
  logic isCtlNow;
  logic inMap;
  logic inCols;
  logic [TYPE_W-1:0] bandIdx;

  assign sof = pixValid && (lineIdx == '0) && (pixIdx == '0);
  assign headerMatch = (pixData[WORD_W-1 -: 8] == SYNC_BYTE) &&
                       (pixData[WORD_W-9 -: 6] == CMD_CFG);
  assign isCtlNow = sof ? headerMatch : frameIsCtl;
  assign inMap  = lineIdx < LINE_W'(MAP_LINES);
  assign inCols = pixIdx < PIX_W'(MAP_PIX);
  assign bandIdx = lineIdx[ROW_W+TYPE_W-1:ROW_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameIsCtl <= 1'b0;
    end else if (sof) begin
      frameIsCtl <= headerMatch;
    end
  end

  always_comb begin
    stb         = '0;
    stb.vidPass = pixValid && !isCtlNow;
    stb.fwdPl   = pixValid && isCtlNow && inMap && inCols;
    stb.chan    = pixIdx[SLOT_W+CH_W-1:SLOT_W];
    stb.slot    = pixIdx[SLOT_W-1:0];
    stb.row     = lineIdx[ROW_W-1:0];
    stb.hdr     = lineIdx[ROW_W-1:0] < ROW_W'(HDR_LINES);
    case (bandIdx)
      2'd0:    stb.plType = REG_CFG;
      2'd1:    stb.plType = REG_PDM;
      default: stb.plType = REG_CAL;
    endcase
  end
endmodule

// File: rtl/ctl_frame_datapath.sv
module ctl_frame_datapath
  import ctl_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [WORD_W-1:0] pixData,
  output logic              vidValid,
  output logic [WORD_W-1:0] vidData,
  output logic [NUM_CH-1:0] plChValid,
  output logic [WORD_W-1:0] plData,
  output logic [TYPE_W-1:0] plType,
  output logic              plHdr,
  output logic [ROW_W-1:0]  plRow,
  output logic [SLOT_W-1:0] plSlot
);
  ctlStrobes_t stbQ;
  logic [WORD_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbQ <= '0;
    end else begin
      stbQ <= stb;
    end
  end

  always_ff @(posedge clk) begin
    dataQ <= pixData;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign plChValid[c] = stbQ.fwdPl && (stbQ.chan == CH_W'(c));
  end

  assign vidValid = stbQ.vidPass;
  assign vidData  = dataQ;
  assign plData   = dataQ;
  assign plType   = stbQ.plType;
  assign plHdr    = stbQ.hdr;
  assign plRow    = stbQ.row;
  assign plSlot   = stbQ.slot;
endmodule

// File: rtl/ctl_frame_extractor.sv
module ctl_frame_extractor
  import ctl_frame_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int PIX_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic [23:0]       pixData,
  input  logic [LINE_W-1:0] lineIdx,
  input  logic [PIX_W-1:0]  pixIdx,
  output logic              vidValid,
  output logic [23:0]       vidData,
  output logic              ctrlFrame,
  output logic [4:0]        plChValid,
  output logic [23:0]       plData,
  output logic [1:0]        plType,
  output logic              plHdr,
  output logic [4:0]        plRow,
  output logic [5:0]        plSlot
);
  ctlStrobes_t stb;

  ctl_frame_ctrl #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .lineIdx(lineIdx), .pixIdx(pixIdx), .stb(stb), .frameIsCtl(ctrlFrame)
  );

  ctl_frame_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pixData(pixData),
    .vidValid(vidValid), .vidData(vidData), .plChValid(plChValid),
    .plData(plData), .plType(plType), .plHdr(plHdr), .plRow(plRow),
    .plSlot(plSlot)
  );
endmodule

// File: rtl/ctl_frame_extractor_chk.sv
module ctl_frame_extractor_chk (
  input logic        clk,
  input logic        rstN,
  input logic [23:0] pixData,
  input logic        vidValid,
  input logic [23:0] vidData,
  input logic        ctrlFrame,
  input logic [4:0]  plChValid,
  input logic [23:0] plData,
  input logic [1:0]  plType,
  input logic        plHdr,
  input logic [4:0]  plRow
);
  AST_CH_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(plChValid)); // R7
  AST_NO_VID_IN_CTL: assert property (@(posedge clk) disable iff (!rstN) ctrlFrame |-> !vidValid); // R4
  AST_NO_PL_IN_VIDEO: assert property (@(posedge clk) disable iff (!rstN) !ctrlFrame |-> (plChValid == 5'd0)); // R3
  AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rstN) (plChValid != 5'd0) |-> (plType != 2'd3)); // R5
  AST_HDR_ROW: assert property (@(posedge clk) disable iff (!rstN) ((plChValid != 5'd0) && plHdr) |-> (plRow < 5'd2)); // R6
  AST_PL_DATA: assert property (@(posedge clk) disable iff (!rstN) (plChValid != 5'd0) |-> (plData == $past(pixData))); // R7
  AST_VID_DATA: assert property (@(posedge clk) disable iff (!rstN) vidValid |-> (vidData == $past(pixData))); // R3
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rstN) !(vidValid && (plChValid != 5'd0))); // R8
endmodule

bind ctl_frame_extractor ctl_frame_extractor_chk u_chk (
  .clk(clk), .rstN(rstN), .pixData(pixData), .vidValid(vidValid),
  .vidData(vidData), .ctrlFrame(ctrlFrame), .plChValid(plChValid),
  .plData(plData), .plType(plType), .plHdr(plHdr), .plRow(plRow)
);

// File: tb/test_ctl_frame_extractor.sv
module test_ctl_frame_extractor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixValid = 1'b0;
  logic [23:0] pixData = '0;
  logic [9:0]  lineIdx = '0;
  logic [9:0]  pixIdx = '0;
  logic        vidValid;
  logic [23:0] vidData;
  logic        ctrlFrame;
  logic [4:0]  plChValid;
  logic [23:0] plData;
  logic [1:0]  plType;
  logic        plHdr;
  logic [4:0]  plRow;
  logic [5:0]  plSlot;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit benchCtl = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctl_frame_extractor i_ctl_frame_extractor (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .lineIdx(lineIdx), .pixIdx(pixIdx), .vidValid(vidValid), .vidData(vidData),
    .ctrlFrame(ctrlFrame), .plChValid(plChValid), .plData(plData),
    .plType(plType), .plHdr(plHdr), .plRow(plRow), .plSlot(plSlot)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] patWord(input int ln, input int px);
    return 24'((ln * 1031 + px * 7 + 24'h5A5A5) & 24'h03FFFF);
  endfunction

  task automatic sendPix(input bit v, input int ln, input int px, input logic [23:0] d);
    bit expPl;
    @(negedge clk);
    pixValid = v; lineIdx = 10'(ln); pixIdx = 10'(px); pixData = d;
    if (v && ln == 0 && px == 0) benchCtl = (d[23:16] == 8'hE8) && (d[15:10] == 6'h3F);
    @(posedge clk); #1;
    expPl = v && benchCtl && ln < 96 && px < 320;
    checkEq("R2_R9", "ctrlFrame", int'(ctrlFrame), int'(benchCtl));
    checkEq("R3_R4", "vidValid", int'(vidValid), int'(v && !benchCtl));
    if (v && !benchCtl) checkEq("R3", "vidData", int'(vidData), int'(d));
    checkEq("R7_R8", "plChValid", int'(plChValid), expPl ? (1 << (px / 64)) : 0);
    if (expPl) begin
      checkEq("R7", "plData", int'(plData), int'(d));
      checkEq("R7", "plSlot", int'(plSlot), px % 64);
      checkEq("R5", "plType", int'(plType), ln / 32);
      checkEq("R6", "plRow", int'(plRow), ln % 32);
      checkEq("R6", "plHdr", int'(plHdr), int'((ln % 32) < 2));
    end
  endtask

  task automatic sendFrame(input logic [23:0] head, input int nLines, input int nPix);
    for (int ln = 0; ln < nLines; ln++) begin
      for (int px = 0; px < nPix; px++) begin
        sendPix(1'b1, ln, px, (ln == 0 && px == 0) ? head : patWord(ln, px));
        if (px == 100) sendPix(1'b0, ln, px, 24'hE8FC00); // R9 idle cycle
      end
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkEq("R1", "vidValid in reset", int'(vidValid), 0);
    checkEq("R1", "ctrlFrame in reset", int'(ctrlFrame), 0);
    checkEq("R1", "plChValid in reset", int'(plChValid), 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkEq("R1", "vidValid after reset", int'(vidValid), 0);
    checkEq("R1", "ctrlFrame after reset", int'(ctrlFrame), 0);
    checkEq("R1", "plChValid after reset", int'(plChValid), 0);
    // R3: picture frame with a near-miss command field
    sendFrame(24'hE8F800, 4, 330);
    // R2 R4 R5 R6 R7 R8: full control frame, beyond both map edges
    sendFrame(24'hE8FC00, 98, 330);
    // R9: near-miss sync byte returns to picture mode
    sendFrame(24'hE9FC00, 2, 330);
    // R2: control again, then a picture frame
    sendFrame(24'hE8FFFF, 3, 330);
    sendFrame(24'h000000, 2, 330);
    finishRun();
  end
endmodule